// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block guards a processor subsystem against software that has stopped making progress. Software arms it by writing a start command with an 8-bit count. While it is armed, the count drops by one on every slow tick, and each tick is 2^PRESCALE_LOG2 system clocks long. The default of 17 gives roughly 763 Hz from a 100 MHz clock. Healthy software writes start again before the count runs out, and that write reloads the count.

The warning comes in two stages. When the count reaches 1, the block raises a non-maskable interrupt request. This gives software one tick to react. When the next tick arrives, the block pulses chip reset for one cycle and disarms itself.

A 7-bit key protects every command. A write takes effect only if its key is the bitwise inverse of the key carried by the last accepted write. Stray or runaway writes therefore cannot re-arm or disarm the watchdog.

Commands arrive on a valid/ready write port. The port never applies back-pressure: `wr_ready` is always high, and the block takes a write in any cycle where `wr_valid` is high. Status outputs are plain signals.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is stopped, `stat_count` is 0, `nmi_req` and `chip_rst` are low, and the expected key is 7'h7F.
- R2: A write with `wr_cmd`=1 (start) and a matching key loads `wr_count` into the counter and sets `stat_running`. The new values are visible on the cycle after the accepting clock edge.
- R3: A write is accepted only when `wr_key` equals the expected key. Each accepted write sets the expected key to `wr_key` XOR 7'h7F.
- R4: A write whose key does not match changes nothing: the counter, the run state, the NMI request and the expected key all stay as they were.
- R5: While running, the counter drops by one every 2^PRESCALE_LOG2 cycles. The first drop comes exactly that many cycles after the load. While stopped, the counter holds its value.
- R6: `nmi_req` rises when the counter becomes 1, including a start that loads 1. It stays high until a reload, an accepted stop or a reset pulse, and it is high only while the count is 1.
- R7: A tick that arrives while the count is 1 (or 0) sets the count to 0 and pulses `chip_rst` high for exactly one cycle. The same tick clears `stat_running` and `nmi_req`.
- R8: A start while running reloads the counter, clears a pending NMI unless the new count is 1, and restarts the tick interval from zero.
- R9: A write with `wr_cmd`=0 (stop) and a matching key clears `stat_running` and `nmi_req`. The count then holds, and no reset follows.
- R10: `wr_ready` is always 1, so writes are never back-pressured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Control write present |
| wr_ready | output | 1 | Always 1; the write is taken in the same cycle |
| wr_cmd | input | 1 | 1 = start/reload, 0 = stop |
| wr_key | input | 7 | Key; must be the inverse of the last accepted key |
| wr_count | input | 8 | Start value for the counter |
| nmi_req | output | 1 | Non-maskable interrupt request (count is 1) |
| chip_rst | output | 1 | One-cycle chip reset pulse |
| stat_running | output | 1 | Watchdog armed |
| stat_count | output | 8 | Current counter value |

## Verification
The counter is run down from several start values, and each one checks a different part of the sequence:
- A start value of 3 exercises the full sequence from plain countdown, through the NMI stage, to the reset pulse.
- A start value of 2 reaches the NMI stage sooner.
- A start value of 1 checks that the NMI rises at load time.
- A start value of 0 checks that the reset comes on the first tick.

The counter is sampled one cycle before and at each tick boundary. This confirms the tick interval exactly, and it shows that a reload restarts the interval rather than continuing the old one. Writes are replayed with the previous key and with a non-inverted key while the watchdog is both stopped and running. This separates ignored writes from accepted ones and confirms that the expected key alternates. Stops are issued both during plain counting and during the NMI stage, and in each case the bench checks that the count is held and no reset pulse appears.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned KEY_W   = 7;
  localparam int unsigned COUNT_W = 8;
  localparam logic [KEY_W-1:0] KEY_FLIP = {KEY_W{1'b1}};

  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } wd_cmd_e;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int unsigned PRESCALE_LOG2 = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  logic [PRESCALE_LOG2-1:0] div_q;

  // tick in the last cycle of each interval
  assign tick = enable && (&div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (clear || !enable)
      div_q <= '0;
    else
      div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_keycheck.sv
module kwdt_keycheck
  import kwdt_pkg::*;
#(
  parameter logic [KEY_W-1:0] INIT_KEY = KEY_FLIP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  output logic             accept,
  output logic [KEY_W-1:0] key_exp
);
  assign accept = wr_valid && (wr_key == key_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      key_exp <= INIT_KEY;
    else if (accept)
      key_exp <= wr_key ^ KEY_FLIP;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_start,
  input  logic               do_stop,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               tick,
  output logic [COUNT_W-1:0] count,
  output logic               running,
  output logic               nmi,
  output logic               bite
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);
  localparam logic [COUNT_W-1:0] TWO = COUNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      nmi     <= 1'b0;
      bite    <= 1'b0;
    end else begin
      bite <= 1'b0;
      if (do_start) begin
        count   <= load_val;
        running <= 1'b1;
        nmi     <= (load_val == ONE);
      end else if (do_stop) begin
        running <= 1'b0;
        nmi     <= 1'b0;
      end else if (running && tick) begin
        if (count <= ONE) begin
          count   <= '0;
          running <= 1'b0;
          nmi     <= 1'b0;
          bite    <= 1'b1;
        end else begin
          count <= count - 1'b1;
          nmi   <= (count == TWO);
        end
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned PRESCALE_LOG2 = 17,
  parameter logic [6:0]  INIT_KEY      = 7'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_cmd,
  input  logic [6:0] wr_key,
  input  logic [7:0] wr_count,
  output logic       nmi_req,
  output logic       chip_rst,
  output logic       stat_running,
  output logic [7:0] stat_count
);
  logic             accept;
  logic [KEY_W-1:0] key_exp;
  logic             do_start;
  logic             do_stop;
  logic             tick;

  assign wr_ready = 1'b1;
  assign do_start = accept && (wd_cmd_e'(wr_cmd) == CMD_START);
  assign do_stop  = accept && (wd_cmd_e'(wr_cmd) == CMD_STOP);

  kwdt_keycheck #(.INIT_KEY(INIT_KEY)) key_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_key   (wr_key),
    .accept   (accept),
    .key_exp  (key_exp)
  );

  kwdt_prescaler #(.PRESCALE_LOG2(PRESCALE_LOG2)) pre_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .enable (stat_running),
    .tick   (tick)
  );

  kwdt_counter cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_start (do_start),
    .do_stop  (do_stop),
    .load_val (wr_count),
    .tick     (tick),
    .count    (stat_count),
    .running  (stat_running),
    .nmi      (nmi_req),
    .bite     (chip_rst)
  );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [6:0] wr_key,
  input logic [6:0] key_exp,
  input logic       running,
  input logic       nmi,
  input logic [7:0] count,
  input logic       chip_rst
);
  // R7
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);

  // R6
  nmi_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> (count == 8'd1) && running);

  // R4
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_key != key_exp)) |=> $stable(key_exp));

  // R9
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(wr_valid) || chip_rst));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !running) |=> $stable(count));

  // R10
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind kwdt_top kwdt_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_key   (wr_key),
  .key_exp  (key_exp),
  .running  (stat_running),
  .nmi      (nmi_req),
  .count    (stat_count),
  .chip_rst (chip_rst)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int unsigned LOG2 = 4;
  localparam int unsigned DIV  = 1 << LOG2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_cmd = 1'b0;
  logic [6:0] wr_key = '0;
  logic [7:0] wr_count = '0;
  logic       nmi_req, chip_rst, stat_running;
  logic [7:0] stat_count;

  typedef struct {
    string      req;
    logic [7:0] cnt;
    logic       run;
    logic       nmi;
    logic       rst;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   rst_pulses = 0;
  bit   done = 1'b0;
  logic [7:0] held;

  always #4 clk = ~clk;

  kwdt_top #(.PRESCALE_LOG2(LOG2)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_cmd       (wr_cmd),
    .wr_key       (wr_key),
    .wr_count     (wr_count),
    .nmi_req      (nmi_req),
    .chip_rst     (chip_rst),
    .stat_running (stat_running),
    .stat_count   (stat_count)
  );

  // driver side: push expected state
  task automatic expect_state(input string req, input logic [7:0] c,
                              input logic r, input logic n, input logic p);
    exp_t e;
    e.req = req; e.cnt = c; e.run = r; e.nmi = n; e.rst = p;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic cmd, input logic [6:0] key, input logic [7:0] cnt);
    wr_valid = 1'b1; wr_cmd = cmd; wr_key = key; wr_count = cnt;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare queued expectations just after each falling edge
  always @(negedge clk) begin
    #1;
    if (chip_rst) rst_pulses++;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (stat_count !== e.cnt || stat_running !== e.run ||
          nmi_req !== e.nmi || chip_rst !== e.rst || wr_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL %s: cnt=%0d run=%b nmi=%b rst=%b rdy=%b expected cnt=%0d run=%b nmi=%b rst=%b rdy=1",
                 e.req, stat_count, stat_running, nmi_req, chip_rst, wr_ready,
                 e.cnt, e.run, e.nmi, e.rst);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: bench hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_state("R1 reset", 8'd0, 0, 0, 0);
    // R4: key 00 is wrong while 7F is expected
    wr(1'b1, 7'h00, 8'd5);
    expect_state("R4 bad key stopped", 8'd0, 0, 0, 0);
    // R2 / R3: first start with 7F
    wr(1'b1, 7'h7F, 8'd3);
    expect_state("R2 start load", 8'd3, 1, 0, 0);
    idle(DIV - 1);
    expect_state("R5 before tick", 8'd3, 1, 0, 0);
    idle(1);
    expect_state("R5 first tick", 8'd2, 1, 0, 0);
    idle(DIV);
    expect_state("R6 nmi at one", 8'd1, 1, 1, 0);
    idle(DIV - 1);
    expect_state("R6 nmi held", 8'd1, 1, 1, 0);
    idle(1);
    expect_state("R7 reset pulse", 8'd0, 0, 0, 1);
    idle(1);
    expect_state("R7 pulse ends", 8'd0, 0, 0, 0);
    // R3: expected key is now 00; replaying 7F must be ignored
    wr(1'b1, 7'h7F, 8'd5);
    expect_state("R3 old key refused", 8'd0, 0, 0, 0);
    wr(1'b1, 7'h00, 8'd5);
    expect_state("R3 inverted key taken", 8'd5, 1, 0, 0);
    idle(DIV + 4);
    expect_state("R5 counting", 8'd4, 1, 0, 0);
    // R8: reload mid-interval restarts interval
    wr(1'b1, 7'h7F, 8'd9);
    expect_state("R8 reload", 8'd9, 1, 0, 0);
    idle(DIV - 1);
    expect_state("R8 interval restarted", 8'd9, 1, 0, 0);
    idle(1);
    expect_state("R8 tick after reload", 8'd8, 1, 0, 0);
    // R4: wrong key stop while running
    wr(1'b0, 7'h7F, 8'd0);
    expect_state("R4 bad stop ignored", 8'd8, 1, 0, 0);
    // R9: correct stop
    wr(1'b0, 7'h00, 8'd0);
    expect_state("R9 stop", 8'd8, 0, 0, 0);
    idle(3 * DIV);
    expect_state("R9 count held", 8'd8, 0, 0, 0);
    // R9: stop during NMI stage
    wr(1'b1, 7'h7F, 8'd2);
    idle(DIV);
    expect_state("R6 nmi from 2", 8'd1, 1, 1, 0);
    wr(1'b0, 7'h00, 8'd0);
    expect_state("R9 stop clears nmi", 8'd1, 0, 0, 0);
    held = 8'd1;
    idle(3 * DIV);
    expect_state("R9 no bite after stop", held, 0, 0, 0);
    idle(1);
    if (rst_pulses != 1) begin
      n_bad++;
      $display("FAIL R7 pulse count: %0d expected 1", rst_pulses);
    end
    n_vec++;
    // R6: load of 1 raises nmi at once
    wr(1'b1, 7'h7F, 8'd1);
    expect_state("R6 load one", 8'd1, 1, 1, 0);
    idle(DIV - 1);
    expect_state("R7 before bite", 8'd1, 1, 1, 0);
    idle(1);
    expect_state("R7 bite from load one", 8'd0, 0, 0, 1);
    // R7: load of 0 bites on first tick
    wr(1'b1, 7'h00, 8'd0);
    expect_state("R7 load zero", 8'd0, 1, 0, 0);
    idle(DIV);
    expect_state("R7 bite from zero", 8'd0, 0, 0, 1);
    idle(2);
    if (rst_pulses != 3) begin
      n_bad++;
      $display("FAIL R7 total pulses: %0d expected 3", rst_pulses);
    end
    n_vec++;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule